// File: doc/BRIEF.md
# Dual-Channel Torque-Off Supervisor

This block decides whether an inverter gate-driver stage may switch. Two independent stop-request channels arrive from outside the chip; each is synchronised and filtered on its own, and the shared gate-driver enable is raised only while both channels ask for torque and the supervisor has been deliberately re-armed. Either channel on its own removes torque. After any torque-off the output stays off until an intentional sequence is completed. The sequence is: both channels at stop, then a re-arm pulse, then both channels back at enable.

The supervisor also watches the channels for faults. A disagreement between the two channels that lasts longer than a set window latches a discrepancy fault. This catches a wire that is open, shorted to a rail, or stuck on one side. While torque is off, a per-channel test pulse can be requested. The block then drives a forced-off line into that channel's wiring and expects to see the stop, and then the release, come back on the channel input within a timeout. A missing response latches a stuck-channel fault. Every exit from the running state produces a one-cycle event for the fault log.

The power-good input models undervoltage or startup. While it is low the enable is removed in the same cycle, and the full re-arm sequence is needed afterwards.

Top module: `sto_supervisor`

## Requirements
- R1: After reset: `drv_en_o`=0, `lock_o`=1, `disc_fault_o`=0, `stuck_fault_o`=0, `trip_evt_o`=0, `tp_a_n_o`=1, `tp_b_n_o`=1. Reset is synchronous and active low.
- R2: A channel input of 1 means enable and 0 means stop. `drv_en_o` is 1 only in the running state, and the running state needs both filtered channels at 1. When one channel drops to 0 and stays there, `drv_en_o` falls exactly DEB_CYC+3 clock cycles after the input changes. Leaving the running state sets `lock_o` to 1.
- R3: A change on a channel input lasting fewer than DEB_CYC cycles has no effect on `drv_en_o`.
- R4: The only way to reach the running state is this order: both filtered channels at stop, then `rearm_i` high for at least one cycle while both are still at stop, then both channels at enable. Raising both channels without the re-arm pulse, or pulsing `rearm_i` while either channel is at enable, keeps `drv_en_o` at 0. This also applies after startup and after every trip.
- R5: When the filtered channels disagree for DISC_CYC consecutive cycles, outside a test, `disc_fault_o` latches to 1. It rises DEB_CYC+DISC_CYC+2 cycles after the input change. It clears only once both filtered channels are at stop. While it is set, re-arm pulses have no effect.
- R6: When `pwr_ok_i` is 0, `drv_en_o` is 0 in the same cycle and `lock_o` is 1 after the next clock edge. Once `pwr_ok_i` returns, the R4 sequence is needed again.
- R7: `trip_evt_o` is 1 for exactly one cycle after each clock edge at which the running state is left, whatever the cause.
- R8: A test request on `tp_a_req_i` or `tp_b_req_i` is accepted under three conditions: `drv_en_o` is 0, no test is in progress, and that channel's filtered input is at enable. Channel A wins if both channels request in the same cycle. On acceptance the channel's `tp_*_n_o` goes to 0 on the next cycle. It stays at 0 until the channel reads stop, and then the block waits for the channel to read enable again. Each of these two phases is limited to TP_TO cycles. A timeout latches `stuck_fault_o`=1, which clears only once both filtered channels are at stop. TP_TO must exceed DEB_CYC+3.
- R9: A test request made while `drv_en_o` is 1, or while that channel is at stop, is ignored: its `tp_*_n_o` stays 1. At most one `tp_*_n_o` is 0 at any time.
- R10: While `disc_fault_o` or `stuck_fault_o` is 1, `drv_en_o` is 0 from the next cycle on and stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pwr_ok_i | input | 1 | Power good; 0 during undervoltage or startup |
| ch_a_i | input | 1 | Channel A stop request, asynchronous; 1 = enable, 0 = stop |
| ch_b_i | input | 1 | Channel B stop request, asynchronous; 1 = enable, 0 = stop |
| rearm_i | input | 1 | Intentional re-arm pulse, synchronous |
| tp_a_req_i | input | 1 | Request a test pulse on channel A |
| tp_b_req_i | input | 1 | Request a test pulse on channel B |
| tp_a_n_o | output | 1 | Forced-off line into channel A wiring, active low |
| tp_b_n_o | output | 1 | Forced-off line into channel B wiring, active low |
| drv_en_o | output | 1 | Gate-driver enable |
| lock_o | output | 1 | 1 whenever the supervisor is not in the running state |
| disc_fault_o | output | 1 | Latched channel-discrepancy fault |
| stuck_fault_o | output | 1 | Latched stuck-channel fault from a test pulse |
| trip_evt_o | output | 1 | One-cycle event on each torque-off |

## Verification
Every result has a fixed due cycle:
- A stop on one channel removes the enable DEB_CYC+3 cycles after the input change, and the trip event appears in that same cycle.
- A discrepancy fault rises DEB_CYC+DISC_CYC+2 cycles after the change.
- A test request lowers the forced-off line one cycle later.
- Loss of power good removes the enable in its own cycle.

The bench drives inputs on the falling edge and counts rising edges up to the due cycle. It samples one cycle before the due cycle, where the old value must still hold, and again at the due cycle, where the new value must appear, so a design that answers early or late is caught. During the random stretch, the bench keeps counts of how long each channel has been held at stop. It requires the enable to be low once either count reaches DEB_CYC+3, and whenever power good is low.

// File: rtl/sto_pkg.sv
// Shared types for the dual-channel torque-off supervisor.
// Assumes: nothing beyond IEEE 1800-2017 enums.
package sto_pkg;

    // Re-arm sequence states; only ARM_RUN drives torque.
    typedef enum logic [1:0] {
        ARM_LOCKED  = 2'd0,
        ARM_STOPPED = 2'd1,
        ARM_PRIMED  = 2'd2,
        ARM_RUN     = 2'd3
    } arm_state_t;

    // Phases of one channel's test pulse.
    typedef enum logic [1:0] {
        TP_IDLE    = 2'd0,
        TP_FORCE   = 2'd1,
        TP_RELEASE = 2'd2
    } tp_phase_t;

    // Number of stop-request channels handled by the supervisor.
    localparam int unsigned NUM_CH = 2;

endpackage

// File: rtl/sto_chan_filter.sv
// Two-flop synchroniser followed by a debounce filter for one channel.
// The filtered output follows the synchronised input only after it has
// differed for DEB_CYC consecutive cycles. Resets to stop (0).
// Assumes: DEB_CYC >= 1.
module sto_chan_filter #(
    parameter int unsigned DEB_CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_i,
    output logic filt_o
);
    localparam int unsigned CW = $clog2(DEB_CYC + 1);
    localparam logic [CW-1:0] CNT_LAST = CW'(DEB_CYC - 1);

    logic          meta_q;
    logic          sync_q;
    logic          filt_q;
    logic [CW-1:0] cnt_q;

    // Bring the asynchronous channel into the clock domain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= 1'b0;
            sync_q <= 1'b0;
        end else begin
            meta_q <= raw_i;
            sync_q <= meta_q;
        end
    end

    // Accept a new level only after it has held for DEB_CYC cycles.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            filt_q <= 1'b0;
            cnt_q  <= '0;
        end else if (sync_q == filt_q) begin
            cnt_q <= '0;
        end else if (cnt_q == CNT_LAST) begin
            filt_q <= sync_q;
            cnt_q  <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign filt_o = filt_q;
endmodule

// File: rtl/sto_disc_mon.sv
// Discrepancy monitor: latches a fault when the filtered channels have
// disagreed for DISC_CYC consecutive unmasked cycles. The fault clears
// only when both channels are at stop.
// Assumes: DISC_CYC >= 1; mask_i is high while a test pulse runs.
module sto_disc_mon #(
    parameter int unsigned DISC_CYC = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic a_i,
    input  logic b_i,
    input  logic mask_i,
    output logic fault_o
);
    localparam int unsigned CW = $clog2(DISC_CYC + 1);
    localparam logic [CW-1:0] CNT_LAST = CW'(DISC_CYC - 1);

    logic [CW-1:0] cnt_q;
    logic          fault_q;
    logic          differ;

    // Disagreement that counts toward the window.
    assign differ = (a_i != b_i) && !mask_i;

    // Count the length of the current disagreement, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!differ) begin
            cnt_q <= '0;
        end else if (cnt_q != CNT_LAST) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Latch the fault; release it once both channels rest at stop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fault_q <= 1'b0;
        end else if (differ && cnt_q == CNT_LAST) begin
            fault_q <= 1'b1;
        end else if (!a_i && !b_i) begin
            fault_q <= 1'b0;
        end
    end

    assign fault_o = fault_q;
endmodule

// File: rtl/sto_pulse_test.sv
// Test-pulse engine for one channel: drives a forced-off line, waits for
// the channel to read stop, releases it, waits for enable again. Each
// phase is limited to TP_TO cycles; a timeout latches a stuck fault that
// clears when clr_i (both channels at stop) is seen.
// Assumes: start_i is only raised when the channel reads enable.
module sto_pulse_test #(
    parameter int unsigned TP_TO = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic filt_i,
    input  logic clr_i,
    output logic drive_n_o,
    output logic busy_o,
    output logic stuck_o
);
    import sto_pkg::*;

    localparam int unsigned TW = $clog2(TP_TO + 1);
    localparam logic [TW-1:0] TMR_LAST = TW'(TP_TO - 1);

    tp_phase_t     phase_q;
    logic [TW-1:0] tmr_q;
    logic          stuck_q;
    logic          timeout;

    // A phase expires when its expected level has not arrived in time.
    always_comb begin
        timeout = 1'b0;
        if (tmr_q == TMR_LAST) begin
            if (phase_q == TP_FORCE && filt_i)
                timeout = 1'b1;
            if (phase_q == TP_RELEASE && !filt_i)
                timeout = 1'b1;
        end
    end

    // Step through force and release phases with a per-phase timer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= TP_IDLE;
            tmr_q   <= '0;
        end else begin
            case (phase_q)
                TP_IDLE: begin
                    if (start_i) begin
                        phase_q <= TP_FORCE;
                        tmr_q   <= '0;
                    end
                end
                TP_FORCE: begin
                    if (!filt_i) begin
                        phase_q <= TP_RELEASE;
                        tmr_q   <= '0;
                    end else if (timeout) begin
                        phase_q <= TP_IDLE;
                    end else begin
                        tmr_q <= tmr_q + 1'b1;
                    end
                end
                TP_RELEASE: begin
                    if (filt_i || timeout) begin
                        phase_q <= TP_IDLE;
                    end else begin
                        tmr_q <= tmr_q + 1'b1;
                    end
                end
                default: phase_q <= TP_IDLE;
            endcase
        end
    end

    // Latch the stuck fault on timeout, clear it on both-stop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stuck_q <= 1'b0;
        end else if (timeout) begin
            stuck_q <= 1'b1;
        end else if (clr_i) begin
            stuck_q <= 1'b0;
        end
    end

    assign drive_n_o = (phase_q != TP_FORCE);
    assign busy_o    = (phase_q != TP_IDLE);
    assign stuck_o   = stuck_q;
endmodule

// File: rtl/sto_arm_fsm.sv
// Re-arm sequencer: enforces stop -> re-arm pulse -> enable before torque,
// drops to the locked state on any stop, fault or power loss, and emits a
// one-cycle event whenever the running state is left.
// Assumes: rearm_i is synchronous; a_i/b_i are filtered levels.
module sto_arm_fsm (
    input  logic clk,
    input  logic rst_n,
    input  logic pwr_ok_i,
    input  logic a_i,
    input  logic b_i,
    input  logic rearm_i,
    input  logic fault_i,
    input  logic busy_i,
    output logic run_o,
    output logic evt_o
);
    import sto_pkg::*;

    arm_state_t state_q;
    arm_state_t state_d;
    logic       evt_q;
    logic       force_lock;
    logic       both_stop;
    logic       both_en;

    assign force_lock = !pwr_ok_i || fault_i;
    assign both_stop  = !a_i && !b_i;
    assign both_en    = a_i && b_i;

    // Next-state selection for the re-arm order.
    always_comb begin
        state_d = state_q;
        case (state_q)
            ARM_LOCKED: begin
                if (!force_lock && both_stop)
                    state_d = ARM_STOPPED;
            end
            ARM_STOPPED: begin
                if (force_lock || !both_stop)
                    state_d = ARM_LOCKED;
                else if (rearm_i)
                    state_d = ARM_PRIMED;
            end
            ARM_PRIMED: begin
                if (force_lock)
                    state_d = ARM_LOCKED;
                else if (both_en && !busy_i)
                    state_d = ARM_RUN;
            end
            ARM_RUN: begin
                if (force_lock || !both_en)
                    state_d = ARM_LOCKED;
            end
            default: state_d = ARM_LOCKED;
        endcase
    end

    // State register and trip-event pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ARM_LOCKED;
            evt_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            evt_q   <= (state_q == ARM_RUN) && (state_d != ARM_RUN);
        end
    end

    assign run_o = (state_q == ARM_RUN);
    assign evt_o = evt_q;
endmodule

// File: rtl/sto_supervisor.sv
// Dual-channel torque-off supervisor top. Filters both stop-request
// channels, runs the discrepancy monitor and per-channel test pulses,
// and sequences the gate-driver enable through the re-arm FSM.
// Assumes: channel inputs are asynchronous, rearm/test requests and
// pwr_ok_i are synchronous to clk; TP_TO > DEB_CYC + 3.
module sto_supervisor #(
    parameter int unsigned DEB_CYC  = 4,
    parameter int unsigned DISC_CYC = 32,
    parameter int unsigned TP_TO    = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pwr_ok_i,
    input  logic ch_a_i,
    input  logic ch_b_i,
    input  logic rearm_i,
    input  logic tp_a_req_i,
    input  logic tp_b_req_i,
    output logic tp_a_n_o,
    output logic tp_b_n_o,
    output logic drv_en_o,
    output logic lock_o,
    output logic disc_fault_o,
    output logic stuck_fault_o,
    output logic trip_evt_o
);
    import sto_pkg::*;

    logic [NUM_CH-1:0] raw;
    logic [NUM_CH-1:0] filt;
    logic [NUM_CH-1:0] tp_req;
    logic [NUM_CH-1:0] tp_start;
    logic [NUM_CH-1:0] tp_drive_n;
    logic [NUM_CH-1:0] tp_busy;
    logic [NUM_CH-1:0] tp_stuck;
    logic              run;
    logic              disc_fault;
    logic              both_stop;
    logic              test_ok;

    assign raw    = {ch_b_i, ch_a_i};
    assign tp_req = {tp_b_req_i, tp_a_req_i};
    assign both_stop = ~|filt;
    assign test_ok   = !run && !(|tp_busy);

    // Grant at most one test start, lowest channel first.
    always_comb begin
        logic taken;
        taken = 1'b0;
        for (int i = 0; i < NUM_CH; i++) begin
            tp_start[i] = tp_req[i] && test_ok && filt[i] && !taken;
            taken       = taken || tp_start[i];
        end
    end

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        sto_chan_filter #(.DEB_CYC(DEB_CYC)) u_filt (
            .clk    (clk),
            .rst_n  (rst_n),
            .raw_i  (raw[g]),
            .filt_o (filt[g])
        );
        sto_pulse_test #(.TP_TO(TP_TO)) u_tp (
            .clk       (clk),
            .rst_n     (rst_n),
            .start_i   (tp_start[g]),
            .filt_i    (filt[g]),
            .clr_i     (both_stop),
            .drive_n_o (tp_drive_n[g]),
            .busy_o    (tp_busy[g]),
            .stuck_o   (tp_stuck[g])
        );
    end

    sto_disc_mon #(.DISC_CYC(DISC_CYC)) u_disc (
        .clk     (clk),
        .rst_n   (rst_n),
        .a_i     (filt[0]),
        .b_i     (filt[1]),
        .mask_i  (|tp_busy),
        .fault_o (disc_fault)
    );

    sto_arm_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .pwr_ok_i (pwr_ok_i),
        .a_i      (filt[0]),
        .b_i      (filt[1]),
        .rearm_i  (rearm_i),
        .fault_i  (disc_fault || (|tp_stuck)),
        .busy_i   (|tp_busy),
        .run_o    (run),
        .evt_o    (trip_evt_o)
    );

    assign drv_en_o      = run && pwr_ok_i;
    assign lock_o        = !run;
    assign disc_fault_o  = disc_fault;
    assign stuck_fault_o = |tp_stuck;
    assign tp_a_n_o      = tp_drive_n[0];
    assign tp_b_n_o      = tp_drive_n[1];
endmodule

// File: rtl/sto_supervisor_chk.sv
// Port-level checker for sto_supervisor, attached with bind below.
// Assumes: synchronous active-low reset on rst_n.
module sto_supervisor_chk (
    input logic clk,
    input logic rst_n,
    input logic pwr_ok_i,
    input logic tp_a_n_o,
    input logic tp_b_n_o,
    input logic drv_en_o,
    input logic lock_o,
    input logic disc_fault_o,
    input logic stuck_fault_o,
    input logic trip_evt_o
);
    // R2: enable is only seen while not locked
    a_r2_en_unlocked: assert property (@(posedge clk) disable iff (!rst_n)
        drv_en_o |-> !lock_o);

    // R6: power loss locks the supervisor on the next edge
    a_r6_pwr_locks: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_ok_i |=> lock_o);

    // R7: each entry into the locked state carries an event
    a_r7_evt_on_lock: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lock_o) |-> trip_evt_o);

    // R7: an event only accompanies a fresh lock
    a_r7_evt_only_fresh: assert property (@(posedge clk) disable iff (!rst_n)
        trip_evt_o |-> (lock_o && !$past(lock_o)));

    // R9: no forced-off line while torque is enabled
    a_r9_no_test_when_en: assert property (@(posedge clk) disable iff (!rst_n)
        drv_en_o |-> (tp_a_n_o && tp_b_n_o));

    // R9: at most one channel is tested at a time
    a_r9_one_test: assert property (@(posedge clk) disable iff (!rst_n)
        (tp_a_n_o || tp_b_n_o));

    // R10: a latched fault removes torque from the next cycle
    a_r10_fault_no_en: assert property (@(posedge clk) disable iff (!rst_n)
        (disc_fault_o || stuck_fault_o) |=> !drv_en_o);
endmodule

bind sto_supervisor sto_supervisor_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .pwr_ok_i      (pwr_ok_i),
    .tp_a_n_o      (tp_a_n_o),
    .tp_b_n_o      (tp_b_n_o),
    .drv_en_o      (drv_en_o),
    .lock_o        (lock_o),
    .disc_fault_o  (disc_fault_o),
    .stuck_fault_o (stuck_fault_o),
    .trip_evt_o    (trip_evt_o)
);

// File: tb/sto_supervisor_test.sv
`timescale 1ns/1ps
module sto_supervisor_test;
    localparam int unsigned DEB  = 4;
    localparam int unsigned DISC = 32;
    localparam int unsigned TPTO = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pwr_ok = 1'b1;
    logic req_a = 1'b1;
    logic req_b = 1'b1;
    logic stuck_a_on = 1'b0;
    logic rearm = 1'b0;
    logic tp_a_req = 1'b0;
    logic tp_b_req = 1'b0;
    logic pin_a, pin_b;
    logic tp_a_n, tp_b_n, drv_en, lock, disc_fault, stuck_fault, trip_evt;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    // Channel wiring: the forced-off line pulls the pin low unless stuck.
    assign pin_a = stuck_a_on ? 1'b1 : (req_a & tp_a_n);
    assign pin_b = req_b & tp_b_n;

    sto_supervisor #(.DEB_CYC(DEB), .DISC_CYC(DISC), .TP_TO(TPTO)) uut (
        .clk(clk), .rst_n(rst_n), .pwr_ok_i(pwr_ok),
        .ch_a_i(pin_a), .ch_b_i(pin_b), .rearm_i(rearm),
        .tp_a_req_i(tp_a_req), .tp_b_req_i(tp_b_req),
        .tp_a_n_o(tp_a_n), .tp_b_n_o(tp_b_n), .drv_en_o(drv_en),
        .lock_o(lock), .disc_fault_o(disc_fault),
        .stuck_fault_o(stuck_fault), .trip_evt_o(trip_evt)
    );

    // Cycles from a held channel change to the enable falling.
    function automatic int unsigned drop_latency();
        return DEB + 3;
    endfunction

    // Cycles from a channel change to the discrepancy fault.
    function automatic int unsigned disc_latency();
        return DEB + DISC + 2;
    endfunction

    // 1 when the requirements forbid the enable in this cycle.
    function automatic bit en_forbidden(int unsigned lo_a, int unsigned lo_b, logic pg);
        return (lo_a >= drop_latency()) || (lo_b >= drop_latency()) || !pg;
    endfunction

    task automatic check(string tag, logic act, logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic tick(int unsigned n);
        repeat (n) @(negedge clk);
    endtask

    // Full intentional re-arm: stop, pulse, enable.
    task automatic arm();
        req_a = 1'b0; req_b = 1'b0;
        tick(DEB + 4);
        rearm = 1'b1; tick(1); rearm = 1'b0;
        req_a = 1'b1; req_b = 1'b1;
        tick(DEB + 4);
    endtask

    initial begin
        int unsigned seed;
        int unsigned lo_a, lo_b, hold_a, hold_b;
        seed = $urandom(32'h5eed);
        tick(5);
        rst_n = 1'b1;
        tick(1);
        // R1 reset state
        check("R1 drv_en", drv_en, 1'b0);
        check("R1 lock", lock, 1'b1);
        check("R1 disc_fault", disc_fault, 1'b0);
        check("R1 stuck_fault", stuck_fault, 1'b0);
        check("R1 trip_evt", trip_evt, 1'b0);
        check("R1 tp_a_n", tp_a_n, 1'b1);
        check("R1 tp_b_n", tp_b_n, 1'b1);

        // R4 startup with both channels already enabled stays off
        tick(20);
        check("R4 startup off", drv_en, 1'b0);
        // R4 stop then enable without re-arm
        req_a = 0; req_b = 0; tick(DEB + 4);
        req_a = 1; req_b = 1; tick(DEB + 4);
        check("R4 no rearm", drv_en, 1'b0);
        // R4 re-arm while channels at enable is ignored
        rearm = 1; tick(1); rearm = 0; tick(DEB + 4);
        check("R4 rearm at enable", drv_en, 1'b0);
        // R4 correct sequence
        arm();
        check("R4 armed en", drv_en, 1'b1);
        check("R4 armed lock", lock, 1'b0);

        // R9 test request while enabled is ignored
        tp_a_req = 1; tick(1); tp_a_req = 0;
        check("R9 tp while en", tp_a_n, 1'b1);
        tick(DEB + 4);
        check("R9 en kept", drv_en, 1'b1);

        // R3 glitch shorter than the filter
        req_b = 0; tick(DEB - 1); req_b = 1; tick(DEB + 4);
        check("R3 glitch ignored", drv_en, 1'b1);

        // R2 exact drop latency and R7 event
        req_a = 0;
        tick(drop_latency() - 1);
        check("R2 en before due", drv_en, 1'b1);
        check("R7 no early evt", trip_evt, 1'b0);
        tick(1);
        check("R2 en dropped", drv_en, 1'b0);
        check("R2 lock set", lock, 1'b1);
        check("R7 evt", trip_evt, 1'b1);
        tick(1);
        check("R7 evt one cycle", trip_evt, 1'b0);
        // R4 latched after channel returns
        req_a = 1; tick(DEB + 4);
        check("R4 stays latched", drv_en, 1'b0);

        // R5 discrepancy fault timing
        req_b = 0;
        tick(disc_latency() - 1);
        check("R5 disc before due", disc_fault, 1'b0);
        tick(1);
        check("R5 disc set", disc_fault, 1'b1);
        rearm = 1; tick(1); rearm = 0; tick(10);
        check("R5 disc held", disc_fault, 1'b1);
        check("R10 no en with fault", drv_en, 1'b0);
        req_a = 0; tick(DEB + 4);
        check("R5 disc cleared", disc_fault, 1'b0);

        // R6 power loss
        arm();
        check("R6 armed", drv_en, 1'b1);
        pwr_ok = 0; #1;
        check("R6 en same cycle", drv_en, 1'b0);
        tick(1);
        check("R6 lock", lock, 1'b1);
        check("R7 evt on pwr", trip_evt, 1'b1);
        pwr_ok = 1; tick(DEB + 4);
        check("R6 re-sequence needed", drv_en, 1'b0);

        // R8 good channel test (locked, both at enable)
        tp_a_req = 1; tick(1); tp_a_req = 0;
        check("R8 tp_a forced", tp_a_n, 1'b0);
        check("R9 tp_b idle", tp_b_n, 1'b1);
        tick(40);
        check("R8 tp_a released", tp_a_n, 1'b1);
        check("R8 no stuck", stuck_fault, 1'b0);
        check("R8 no disc during test", disc_fault, 1'b0);

        // R8 stuck channel A
        stuck_a_on = 1;
        tp_a_req = 1; tick(1); tp_a_req = 0;
        tick(TPTO + 4);
        check("R8 stuck set", stuck_fault, 1'b1);
        check("R8 line released", tp_a_n, 1'b1);
        check("R10 no en with stuck", drv_en, 1'b0);
        stuck_a_on = 0; req_a = 0; req_b = 0; tick(DEB + 4);
        check("R8 stuck cleared", stuck_fault, 1'b0);
        // R9 request on a channel at stop
        tp_b_req = 1; tick(1); tp_b_req = 0;
        check("R9 tp at stop", tp_b_n, 1'b1);

        // R2 random stress: long stop on either channel forbids enable
        arm();
        lo_a = 0; lo_b = 0; hold_a = 0; hold_b = 0;
        for (int c = 0; c < 4000; c++) begin
            @(negedge clk);
            lo_a = req_a ? 0 : lo_a + 1;
            lo_b = req_b ? 0 : lo_b + 1;
            if (en_forbidden(lo_a, lo_b, pwr_ok))
                check("R2 random en forbidden", drv_en, 1'b0);
            if (hold_a == 0) begin
                req_a = ($urandom % 5) != 0;
                hold_a = $urandom_range(1, 3 * DEB + 12);
            end else hold_a--;
            if (hold_b == 0) begin
                req_b = ($urandom % 5) != 0;
                hold_b = $urandom_range(1, 3 * DEB + 12);
            end else hold_b--;
            rearm = ($urandom % 12) == 0;
            pwr_ok = ($urandom % 300) != 0;
        end
        rearm = 0; pwr_ok = 1;
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end
endmodule